// File: doc/BRIEF.md
# System Address Route Decoder

This block takes a physical system address and resolves which socket, which memory controller and which channel on that controller own it. A requester places the address on `addr` and pulses `start`. The block first rejects addresses that fall in the I/O hole below 4 GiB or at or above the top of high memory. It then walks a table of address rules, one entry per clock, through a read port to an external register file. Each entry returns a rule word and an interleave-list word.

When an entry matches, a small field of the address selects a 4-bit target from the interleave list. The target either names a remote socket or gives a local logical channel. A remote target makes the block switch once to that socket's rule set and walk it from the start. A second remote target ends the lookup with an error. A local hit yields a logical channel, taken either from the target itself or from a modulo-3 or modulo-2 function of shifted address bits. The logical channel then indexes the socket's route word, which gives the controller and channel numbers.

The controller is a four-state machine:
- `S_IDLE` waits for `start`. It moves to `S_SCAN`, or straight to `S_FINISH` when the range check fails.
- `S_SCAN` issues one rule read per cycle and evaluates the entry read the cycle before. It moves to `S_HOP` on the first remote target. It moves to `S_FINISH` on a local hit, on any error, or after the last entry.
- `S_HOP` is a single bubble cycle. It discards the read still in flight and returns to `S_SCAN` on the new socket.
- `S_FINISH` presents the result for one cycle and returns to `S_IDLE`.

Top module: `sysaddr_route_decoder`

## Requirements
- R1: An address at or above `tohm` finishes with `fail_code` 1 (range) and issues no rule read.
- R2: An address at or above `tolm` and below 2^32 finishes with `fail_code` 1. Addresses below `tolm`, or from 2^32 up to `tohm`, go on to the scan.
- R3: Entries are examined in index order 0 to NUM_RULES-1, with a lower bound that starts at 0.
  - The limit of an entry is rule bits 26:7 placed at address bit 26, with address bits 25:0 all ones.
  - An entry hits when rule bit 0 is set and lower bound <= addr <= limit.
  - After every examined entry, enabled or not, the lower bound becomes limit+1.
  - If no entry hits, the result is `fail_code` 2.
- R4: Rule bits 2:1 choose a 3-bit index from the address: code 0 uses bits 8:6, code 1 uses bits 10:8, code 2 uses bits 14:12, and code 3 uses bits 32:30.
- R5: The target is interleave-list bits [4*index+3 : 4*index]. Target bit 3 set means local. When rule bit 27 is clear, the logical channel is the target's bits 2:0.
- R6: On a remote target (bit 3 clear), the block rescans from entry 0, with lower bound 0, on the lowest-numbered socket whose 3-bit source ID equals target bits 2:0. `res_socket` is the source ID of the socket that resolves the address.
- R7: A remote target met after a hop finishes with `fail_code` 3.
- R8: A remote target that no socket's source ID matches finishes with `fail_code` 4.
- R9: With rule bit 27 set, let v = addr >> s, where s is 6, 8 or 12 for rule bits 31:30 equal to 0, 1 or 2. Rule bits 6:5 then select the logical channel:
  - 0 gives v mod 3.
  - 1 gives v mod 2.
  - 2 gives 2*(v mod 2) + (1 - v mod 2).
  - 3 gives 2*(v mod 2).
- R10: With rule bit 27 set, rule bits 31:30 equal to 3 finish with `fail_code` 5. With bit 27 clear, those bits have no effect.
- R11: For logical channel l, the controller is route bits [3l+2:3l] and the channel is route bits [2l+19:2l+18]. Route bits above 31 read as zero.
- R12: `done` is high for exactly one cycle per accepted `start`. `fail` is high with a non-zero `fail_code` and low with code 0. A `start` while the block is busy is ignored.
- R13: Reads go out at one entry per cycle with `rd_idx` < NUM_RULES, and data returns on the next cycle. A hit on entry k raises `done` k+3 clock edges after `start` is taken. A full miss on one socket reads exactly NUM_RULES entries.
- R14: After reset, `done` and `rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a lookup (taken in idle only) |
| addr | input | 46 | System address to resolve |
| tolm | input | 46 | Top of low memory |
| tohm | input | 46 | Top of high memory (exclusive) |
| sock_src_id | input | 3*NUM_SOCK | Source ID of each socket, socket 0 in the low bits |
| sock_route | input | 32*NUM_SOCK | Route word of each socket, socket 0 in the low bits |
| rd_en | output | 1 | Rule read request |
| rd_sock | output | SOCK_W | Socket whose rule set is read |
| rd_idx | output | IDX_W | Rule entry index |
| rd_rule | input | 32 | Rule word, one cycle after the request |
| rd_ilv | input | 32 | Interleave-list word, one cycle after the request |
| done | output | 1 | One-cycle result strobe |
| fail | output | 1 | Lookup failed |
| fail_code | output | 3 | 0 ok, 1 range, 2 no rule, 3 double remote, 4 no socket, 5 bad shift |
| res_socket | output | 3 | Source ID of the resolving socket |
| res_mc | output | 3 | Memory controller number |
| res_chan | output | 2 | Channel number |

## Verification
The bench builds the block with NUM_SOCK = 3 and the default NUM_RULES = 24. Three sockets make the following reachable in one run:
- a successful hop to a socket other than socket 0;
- a hop that lands on a socket whose own table points away again (the double-remote case);
- a remote target whose source ID no socket carries.

Keeping all 24 entries lets the bench hit entries deep in the table, so it can measure latency against the entry position. It also lets a full miss walk every entry, including the disabled entries that still advance the lower bound.

// File: rtl/sad_pkg.sv
package sad_pkg;
    localparam int AW      = 46;   // system address width
    localparam int WORD_W  = 32;   // rule / interleave / route word width
    localparam int SRC_W   = 3;    // socket source ID width
    localparam int GRAN_LSB = 26;  // rule limit granularity

    typedef enum logic [2:0] {
        E_NONE   = 3'd0,
        E_RANGE  = 3'd1,
        E_NORULE = 3'd2,
        E_DBLREM = 3'd3,
        E_NOSOCK = 3'd4,
        E_MODE   = 3'd5
    } err_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SCAN,
        S_HOP,
        S_FINISH
    } state_e;
endpackage

// File: rtl/sad_range_chk.sv
module sad_range_chk import sad_pkg::*; (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] tolm,
    input  logic [AW-1:0] tohm,
    output logic          out_of_range
);
    logic below_4g;
    assign below_4g     = (addr[AW-1:32] == '0);
    assign out_of_range = (addr >= tohm) || ((addr >= tolm) && below_4g);
endmodule

// File: rtl/sad_target_pick.sv
module sad_target_pick import sad_pkg::*; (
    input  logic [AW-1:0]     addr,
    input  logic [1:0]        ilv_sel,
    input  logic [WORD_W-1:0] ilv_word,
    output logic [3:0]        tgt
);
    logic [2:0] nib_idx;

    always_comb begin
        unique case (ilv_sel)
            2'd0: nib_idx = addr[8:6];
            2'd1: nib_idx = addr[10:8];
            2'd2: nib_idx = addr[14:12];
            2'd3: nib_idx = addr[32:30];
        endcase
        tgt = ilv_word[4*nib_idx +: 4];
    end

    logic unused_addr;
    assign unused_addr = ^{addr[AW-1:33], addr[29:15], addr[11], addr[5:0]};
endmodule

// File: rtl/sad_lchan_route.sv
module sad_lchan_route import sad_pkg::*; (
    input  logic [AW-1:0]     addr,
    input  logic              mod_en,
    input  logic [1:0]        shift_code,
    input  logic [1:0]        mod_mode,
    input  logic [2:0]        tgt_chan,
    input  logic [WORD_W-1:0] route,
    output logic [2:0]        mc,
    output logic [1:0]        chan,
    output logic              bad_shift
);
    localparam int DIGITS = (AW + 1) / 2;

    // residue mod 3 by folding base-4 digits, most significant first
    function automatic logic [1:0] fold_mod3(input logic [2*DIGITS-1:0] v);
        logic [1:0] r;
        logic [3:0] t;
        r = 2'd0;
        for (int d = DIGITS - 1; d >= 0; d--) begin
            t = {r, 2'b00} + {2'b00, v[2*d +: 2]};
            r = 2'(t % 4'd3);
        end
        return r;
    endfunction

    int                       sh;
    logic [AW-1:0]            shifted;
    logic [2:0]               mod_chan;
    logic [2:0]               lchan;
    logic [WORD_W+7:0]        route_ext;

    always_comb begin
        bad_shift = 1'b0;
        unique case (shift_code)
            2'd0: sh = 6;
            2'd1: sh = 8;
            2'd2: sh = 12;
            default: begin
                sh        = 0;
                bad_shift = mod_en;
            end
        endcase
        shifted = addr >> sh;
        unique case (mod_mode)
            2'd0: mod_chan = {1'b0, fold_mod3({{(2*DIGITS-AW){1'b0}}, shifted})};
            2'd1: mod_chan = {2'b00, shifted[0]};
            2'd2: mod_chan = {1'b0, shifted[0], ~shifted[0]};
            2'd3: mod_chan = {1'b0, shifted[0], 1'b0};
        endcase
        lchan = mod_en ? mod_chan : tgt_chan;
    end

    assign route_ext = {8'h00, route};
    assign mc        = route_ext[3*lchan +: 3];
    assign chan      = route_ext[2*lchan + 18 +: 2];
endmodule

// File: rtl/sad_socket_find.sv
module sad_socket_find import sad_pkg::*; #(
    parameter int NUM_SOCK = 2,
    parameter int SOCK_W   = 1
) (
    input  logic [NUM_SOCK*SRC_W-1:0] src_ids,
    input  logic [SRC_W-1:0]          want,
    output logic                      found,
    output logic [SOCK_W-1:0]         sock_idx
);
    always_comb begin
        found    = 1'b0;
        sock_idx = '0;
        for (int s = NUM_SOCK - 1; s >= 0; s--) begin
            if (src_ids[s*SRC_W +: SRC_W] == want) begin
                found    = 1'b1;
                sock_idx = SOCK_W'(s);
            end
        end
    end
endmodule

// File: rtl/sysaddr_route_decoder.sv
module sysaddr_route_decoder import sad_pkg::*; #(
    parameter  int NUM_RULES = 24,
    parameter  int NUM_SOCK  = 2,
    localparam int SOCK_W    = (NUM_SOCK > 1) ? $clog2(NUM_SOCK) : 1,
    localparam int IDX_W     = $clog2(NUM_RULES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [AW-1:0]              addr,
    input  logic [AW-1:0]              tolm,
    input  logic [AW-1:0]              tohm,
    input  logic [NUM_SOCK*SRC_W-1:0]  sock_src_id,
    input  logic [NUM_SOCK*WORD_W-1:0] sock_route,
    output logic                       rd_en,
    output logic [SOCK_W-1:0]          rd_sock,
    output logic [IDX_W-1:0]           rd_idx,
    input  logic [WORD_W-1:0]          rd_rule,
    input  logic [WORD_W-1:0]          rd_ilv,
    output logic                       done,
    output logic                       fail,
    output logic [2:0]                 fail_code,
    output logic [SRC_W-1:0]           res_socket,
    output logic [2:0]                 res_mc,
    output logic [1:0]                 res_chan
);
    state_e            state, nxt;
    err_e              fin_code, code_q;
    logic [AW-1:0]     addr_q;
    logic [SOCK_W-1:0] sock_q;
    logic [IDX_W-1:0]  issue_q;
    logic              eval_q;
    logic [AW:0]       lo_q;
    logic              hopped_q;
    logic              fail_q;
    logic [SRC_W-1:0]  res_sock_q;
    logic [2:0]        res_mc_q;
    logic [1:0]        res_chan_q;

    // ---------------- datapath helpers ----------------
    logic              oor;
    logic [AW-1:0]     limit;
    logic              hit;
    logic [3:0]        tgt;
    logic              remote;
    logic              sock_found;
    logic [SOCK_W-1:0] found_idx;
    logic [2:0]        mc_w;
    logic [1:0]        chan_w;
    logic              bad_shift;
    logic [WORD_W-1:0] cur_route;
    logic [SRC_W-1:0]  cur_src;

    sad_range_chk u_range (
        .addr         (addr),
        .tolm         (tolm),
        .tohm         (tohm),
        .out_of_range (oor)
    );

    sad_target_pick u_pick (
        .addr     (addr_q),
        .ilv_sel  (rd_rule[2:1]),
        .ilv_word (rd_ilv),
        .tgt      (tgt)
    );

    sad_socket_find #(.NUM_SOCK(NUM_SOCK), .SOCK_W(SOCK_W)) u_find (
        .src_ids  (sock_src_id),
        .want     (tgt[2:0]),
        .found    (sock_found),
        .sock_idx (found_idx)
    );

    assign cur_route = sock_route[int'(sock_q)*WORD_W +: WORD_W];
    assign cur_src   = sock_src_id[int'(sock_q)*SRC_W +: SRC_W];

    sad_lchan_route u_route (
        .addr       (addr_q),
        .mod_en     (rd_rule[27]),
        .shift_code (rd_rule[31:30]),
        .mod_mode   (rd_rule[6:5]),
        .tgt_chan   (tgt[2:0]),
        .route      (cur_route),
        .mc         (mc_w),
        .chan       (chan_w),
        .bad_shift  (bad_shift)
    );

    assign limit  = {rd_rule[26:7], {GRAN_LSB{1'b1}}};
    assign hit    = eval_q && rd_rule[0] && ({1'b0, addr_q} >= lo_q) && (addr_q <= limit);
    assign remote = ~tgt[3];

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // ---------------- next state ----------------
    always_comb begin
        nxt      = state;
        fin_code = E_NONE;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    if (oor) begin
                        nxt      = S_FINISH;
                        fin_code = E_RANGE;
                    end else begin
                        nxt = S_SCAN;
                    end
                end
            end
            S_SCAN: begin
                if (hit) begin
                    if (remote) begin
                        if (hopped_q) begin
                            nxt      = S_FINISH;
                            fin_code = E_DBLREM;
                        end else if (!sock_found) begin
                            nxt      = S_FINISH;
                            fin_code = E_NOSOCK;
                        end else begin
                            nxt = S_HOP;
                        end
                    end else begin
                        nxt      = S_FINISH;
                        fin_code = bad_shift ? E_MODE : E_NONE;
                    end
                end else if (eval_q && issue_q == IDX_W'(NUM_RULES)) begin
                    nxt      = S_FINISH;
                    fin_code = E_NORULE;
                end
            end
            S_HOP:    nxt = S_SCAN;
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        rd_en      = (state == S_SCAN) && (issue_q < IDX_W'(NUM_RULES));
        rd_sock    = sock_q;
        rd_idx     = issue_q;
        done       = (state == S_FINISH);
        fail       = fail_q;
        fail_code  = code_q;
        res_socket = res_sock_q;
        res_mc     = res_mc_q;
        res_chan   = res_chan_q;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            sock_q     <= '0;
            issue_q    <= '0;
            eval_q     <= 1'b0;
            lo_q       <= '0;
            hopped_q   <= 1'b0;
            code_q     <= E_NONE;
            fail_q     <= 1'b0;
            res_sock_q <= '0;
            res_mc_q   <= '0;
            res_chan_q <= '0;
        end else begin
            eval_q <= rd_en;
            if (state == S_IDLE && start) begin
                addr_q   <= addr;
                sock_q   <= '0;
                issue_q  <= '0;
                lo_q     <= '0;
                hopped_q <= 1'b0;
            end
            if (state == S_SCAN) begin
                if (rd_en)  issue_q <= issue_q + 1'b1;
                if (eval_q) lo_q    <= {1'b0, limit} + 1'b1;
                if (nxt == S_HOP) begin
                    sock_q   <= found_idx;
                    hopped_q <= 1'b1;
                    issue_q  <= '0;
                    lo_q     <= '0;
                end
            end
            if (nxt == S_FINISH && state != S_FINISH) begin
                code_q     <= fin_code;
                fail_q     <= (fin_code != E_NONE);
                res_sock_q <= cur_src;
                res_mc_q   <= mc_w;
                res_chan_q <= chan_w;
            end
        end
    end

    logic unused_attr;
    assign unused_attr = ^rd_rule[4:3];

    // ---------------- assertions ----------------
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_fail_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fail == (fail_code != 3'd0)));

    p_read_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_idx < IDX_W'(NUM_RULES)));

    p_read_only_scan_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_SCAN) |-> !rd_en);

    p_range_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && oor) |=> (done && fail_code == 3'd1));

    p_single_hop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOP) |=> hopped_q);

    p_bad_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SCAN && hit && !remote && rd_rule[27] && rd_rule[31:30] == 2'b11)
        |=> (done && fail_code == 3'd5));
endmodule

// File: tb/sim_sysaddr_route_decoder.sv
`timescale 1ns/1ps
module sim_sysaddr_route_decoder;
    localparam int NS = 3;
    localparam int NR = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [45:0] addr = '0;
    logic [45:0] tolm = 46'h0_8000_0000;
    logic [45:0] tohm = 46'h10_0000_0000;
    logic [8:0]  src_ids = {3'd1, 3'd5, 3'd2};
    logic [95:0] routes  = {32'h0, 32'h00C0_01C0, 32'hDB1B_58D1};
    logic        rd_en;
    logic [1:0]  rd_sock;
    logic [4:0]  rd_idx;
    logic [31:0] rd_rule = '0;
    logic [31:0] rd_ilv = '0;
    logic        done, fail;
    logic [2:0]  fail_code, res_socket, res_mc;
    logic [1:0]  res_chan;

    always #10 clk = ~clk;

    sysaddr_route_decoder #(.NUM_RULES(NR), .NUM_SOCK(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr),
        .tolm(tolm), .tohm(tohm), .sock_src_id(src_ids), .sock_route(routes),
        .rd_en(rd_en), .rd_sock(rd_sock), .rd_idx(rd_idx),
        .rd_rule(rd_rule), .rd_ilv(rd_ilv),
        .done(done), .fail(fail), .fail_code(fail_code),
        .res_socket(res_socket), .res_mc(res_mc), .res_chan(res_chan)
    );

    // register file model, one-cycle read latency
    logic [31:0] rule_m [NS][NR];
    logic [31:0] ilv_m  [NS][NR];
    int          reads;
    always @(posedge clk) begin
        if (rd_en) begin
            rd_rule <= rule_m[rd_sock][rd_idx];
            rd_ilv  <= ilv_m[rd_sock][rd_idx];
            reads   <= reads + 1;
        end
    end

    int total = 0;
    int bad = 0;
    int pushed = 0;
    int popped = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // scoreboard queues
    logic [2:0] q_code[$];
    logic [2:0] q_sock[$];
    logic [2:0] q_mc[$];
    logic [1:0] q_chan[$];
    string      q_tag[$];

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                popped++;
                if (q_code.size() == 0) begin
                    chk(1'b0, "R12", "unexpected done", 1, 0);
                end else begin
                    automatic logic [2:0] ec = q_code.pop_front();
                    automatic logic [2:0] es = q_sock.pop_front();
                    automatic logic [2:0] em = q_mc.pop_front();
                    automatic logic [1:0] eh = q_chan.pop_front();
                    automatic string      tg = q_tag.pop_front();
                    chk(fail_code == ec, tg, "fail_code", fail_code, ec);
                    chk(fail == (ec != 3'd0), "R12", "fail flag", fail, ec != 3'd0);
                    if (ec == 3'd0) begin
                        chk({res_socket, res_mc, res_chan} == {es, em, eh}, tg,
                            "socket/mc/chan", {res_socket, res_mc, res_chan}, {es, em, eh});
                    end
                end
                @(negedge clk);
                chk(!done, "R12", "done width", done, 0);
            end
        end
    end

    function automatic logic [31:0] mk(input bit en, input int il, input int lim,
                                       input int mode, input bit m3, input int sh);
        return (32'(sh) << 30) | (32'(m3) << 27) | (32'(lim) << 7) |
               (32'(mode) << 5) | (32'(il) << 1) | 32'(en);
    endfunction

    // driver: push expectation, start, measure latency and reads
    task automatic xact(input logic [45:0] a, input logic [2:0] ec, input logic [2:0] es,
                        input logic [2:0] em, input logic [1:0] eh, input string tg,
                        input int exp_lat, input int exp_reads, input bit poke);
        int lat;
        q_code.push_back(ec); q_sock.push_back(es); q_mc.push_back(em);
        q_chan.push_back(eh); q_tag.push_back(tg);
        pushed++;
        @(negedge clk);
        addr  = a;
        start = 1'b1;
        reads = 0;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            if (poke && lat == 2) begin
                start = 1'b1;
                addr  = 46'h0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        if (exp_lat >= 0) chk(lat == exp_lat, "R13", "latency", lat, exp_lat);
        if (exp_reads >= 0) chk(reads == exp_reads, "R13", "read count", reads, exp_reads);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < NS; s++) begin
            for (int e = 0; e < NR; e++) begin
                rule_m[s][e] = '0;
                ilv_m[s][e]  = '0;
            end
        end
        // socket 0 (source ID 2)
        rule_m[0][0]  = mk(1, 0, 'h01, 0, 0, 0); ilv_m[0][0]  = 32'hFEDC_BA98;
        rule_m[0][1]  = mk(0, 0, 'h03, 0, 0, 0); ilv_m[0][1]  = 32'hFEDC_BA98;
        rule_m[0][2]  = mk(1, 1, 'h07, 0, 0, 0); ilv_m[0][2]  = 32'hFEDC_BA98;
        rule_m[0][3]  = mk(1, 2, 'h09, 0, 1, 0); ilv_m[0][3]  = 32'hFEDC_BA98;
        rule_m[0][4]  = mk(1, 0, 'h0B, 1, 1, 1); ilv_m[0][4]  = 32'hFEDC_BA98;
        rule_m[0][5]  = mk(1, 0, 'h0D, 2, 1, 2); ilv_m[0][5]  = 32'hFEDC_BA98;
        rule_m[0][6]  = mk(1, 0, 'h0F, 3, 1, 0); ilv_m[0][6]  = 32'hFEDC_BA98;
        rule_m[0][7]  = mk(1, 0, 'h11, 0, 1, 3); ilv_m[0][7]  = 32'hFEDC_BA98;
        rule_m[0][8]  = mk(1, 0, 'h13, 0, 0, 0); ilv_m[0][8]  = 32'h5555_5555;
        rule_m[0][9]  = mk(1, 0, 'h15, 0, 0, 0); ilv_m[0][9]  = 32'h4444_4444;
        rule_m[0][10] = mk(1, 0, 'h17, 0, 0, 0); ilv_m[0][10] = 32'h1111_1111;
        rule_m[0][11] = mk(1, 3, 'h47, 0, 0, 0); ilv_m[0][11] = 32'hFEDC_BA98;
        // socket 1 (source ID 5); shift bits 3 with mod-3 off must not matter
        rule_m[1][0]  = mk(1, 0, 'h1F, 0, 0, 3); ilv_m[1][0]  = 32'hAAAA_AAAA;
        // socket 2 (source ID 1) points away again
        rule_m[2][0]  = mk(1, 0, 'h1F, 0, 0, 0); ilv_m[2][0]  = 32'h2222_2222;

        repeat (3) @(negedge clk);
        chk(!done && !rd_en, "R14", "reset outputs", {done, rd_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !rd_en, "R14", "idle after reset", {done, rd_en}, 0);

        // R4 R5 R11: entry 0, index from bits 8:6
        xact(46'h0_0000_0140, 0, 2, 6, 1, "R4", 3, -1, 0);
        xact(46'h0_0000_0000, 0, 2, 1, 2, "R5", 3, -1, 0);
        // R3 upper bound inclusive; R11 lchan 7 reads zero above route bit 31
        xact(46'h0_07FF_FFFF, 0, 2, 0, 0, "R11", 3, -1, 0);
        // R3 disabled entry still advances the lower bound, so no hit
        xact(46'h0_0C00_0000, 2, 0, 0, 0, "R3", 3 + 23, NR, 0);
        // R4 code 1 (bits 10:8); R12 start during scan ignored
        xact(46'h0_1000_0300, 0, 2, 4, 3, "R12", 3 + 2, -1, 1);
        // R9 mode 0 mod 3, shift 6
        xact(46'h0_2000_0080, 0, 2, 2, 1, "R9", 3 + 3, -1, 0);
        xact(46'h0_2000_0000, 0, 2, 3, 0, "R9", -1, -1, 0);
        xact(46'h0_2000_0040, 0, 2, 1, 2, "R9", -1, -1, 0);
        // R9 mode 1 mod 2, shift 8
        xact(46'h0_2800_0100, 0, 2, 2, 1, "R9", -1, -1, 0);
        xact(46'h0_2800_0000, 0, 2, 1, 2, "R9", -1, -1, 0);
        // R9 mode 2, shift 12
        xact(46'h0_3000_1000, 0, 2, 3, 0, "R9", -1, -1, 0);
        xact(46'h0_3000_0000, 0, 2, 2, 1, "R9", -1, -1, 0);
        // R9 mode 3, shift 6
        xact(46'h0_3800_0040, 0, 2, 3, 0, "R9", -1, -1, 0);
        xact(46'h0_3800_0000, 0, 2, 1, 2, "R9", -1, -1, 0);
        // R10 illegal shift code
        xact(46'h0_4000_0000, 5, 0, 0, 0, "R10", -1, -1, 0);
        // R6 hop to socket 1, R10 shift bits ignored there, R11 route of socket 1
        xact(46'h0_4800_0000, 0, 5, 7, 3, "R6", -1, -1, 0);
        // R8 no socket with ID 4
        xact(46'h0_5000_0000, 4, 0, 0, 0, "R8", -1, -1, 0);
        // R7 second remote
        xact(46'h0_5800_0000, 3, 0, 0, 0, "R7", -1, -1, 0);
        // R2 boundaries around the hole; R4 code 3 bits 32:30
        xact(46'h0_7FFF_FFFF, 0, 2, 2, 1, "R2", 3 + 11, -1, 0);
        xact(46'h0_8000_0000, 1, 0, 0, 0, "R2", 1, 0, 0);
        xact(46'h0_FFFF_FFFF, 1, 0, 0, 0, "R2", 1, 0, 0);
        xact(46'h1_0000_0000, 0, 2, 5, 2, "R4", -1, -1, 0);
        // R3 above all rules; R1 top of high memory
        xact(46'h2_0000_0000, 2, 0, 0, 0, "R3", -1, NR, 0);
        xact(46'hF_FFFF_FFFF, 2, 0, 0, 0, "R1", -1, -1, 0);
        xact(46'h10_0000_0000, 1, 0, 0, 0, "R1", 1, 0, 0);

        repeat (4) @(negedge clk);
        chk(popped == pushed && q_code.size() == 0, "R12", "done count",
            popped, pushed);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule